// File: doc/BRIEF.md
# ADC Controller Register Interface

This block is the software-facing side of a successive-approximation converter. A host reaches it through a single-cycle port that carries a valid strobe, a write flag, a byte address and a data word. Through that port software chooses an input channel, enables interrupts, sets the result overwrite policy and the averaging and continuous-conversion controls, and launches calibration. The block turns these register accesses into one-cycle start, stop and calibrate strobes for an external conversion sequencer. It captures results that the sequencer reports with a done strobe.

Writing a channel number to channel control 0 launches a conversion. The all-ones code halts the converter instead. A completion flag, readable in the status register, marks a fresh result and is cleared by reading the result. When continuous mode is on, every completion immediately launches another conversion on the same channel. Calibration runs through a self-clearing control bit. If software touches channel control 0 while calibration is running, the calibration is abandoned and a failure flag is raised.

Top module: `adc_regif`

## Requirements
- R1: Only word-aligned addresses from 0x00 to 0x30 are accepted. Any other access raises `bus_err` in the following cycle, a rejected write changes no register, and a rejected read returns zero.
- R2: Channel control 0 (0x00) holds the channel select in bits [4:0] and the interrupt enable in bit 7. It reads back 0x1F after reset.
- R3: A write to 0x00 with a channel code other than 0x1F gives a one-cycle `conv_start` in the next cycle, with `conv_chan` equal to the code. Code 0x1F gives a one-cycle `conv_stop` there and no start.
- R4: A `conv_done` pulse sets status bit 0 (0x08) and stores `conv_result` into result 0 (0x0C), which reads it in its low bits.
- R5: A read of 0x0C clears the completion flag, and so does any accepted write to 0x00.
- R6: `irq` is high while the completion flag and the interrupt enable are both set, and low after reset.
- R7: Configuration register bit 16 (0x14) enables overwrite. While it is clear and the completion flag is set, a new `conv_done` leaves result 0 unchanged. While it is set, the newer result replaces the older one.
- R8: When general control bit 6 (0x18) is set and the channel code is not 0x1F, each `conv_done` produces a `conv_start` in the next cycle on the same channel. After 0x1F is written, no such restart happens.
- R9: Writing 1 to general control bit 7 gives a one-cycle `cal_start`, and bit 7 then reads 1 until `cal_done` clears it. If the interrupt enable is set at completion, `irq` stays high until general status (0x1C) is read. General status bit 0 mirrors the calibration-active state.
- R10: An accepted write to 0x00 while calibration is active ends calibration and sets general status bit 1. The next calibration start clears that bit.
- R11: General control bit 5 drives `avg_en`. The registers at 0x04, 0x14 (17 bits), 0x20, 0x24, 0x28 and 0x30 read back what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after the access |
| bus_err | output | 1 | Rejected access, the cycle after it |
| irq | output | 1 | Interrupt request |
| conv_start | output | 1 | Start-conversion strobe to the sequencer |
| conv_stop | output | 1 | Stop strobe to the sequencer |
| conv_chan | output | 5 | Selected input channel |
| conv_done | input | 1 | Conversion finished strobe |
| conv_result | input | 12 | Result of the finished conversion |
| cal_start | output | 1 | Calibration start strobe |
| cal_done | input | 1 | Calibration finished strobe |
| avg_en | output | 1 | Hardware averaging enable |

## Verification
On every cycle, the assertions check several rules. Rejected addresses raise the error flag. Start and stop strobes never coincide. A pending flag with interrupts enabled always drives the interrupt. An unread result survives a new completion while overwrite is off. Calibration clears itself on done, and an abort leaves the failure flag set. The bench scenarios show behaviour that spans several accesses. These include the readback of each register, the clearing of the flag by a result read, restarts in continuous mode ending after the stop code, and the calibration interrupt lasting until the status read. A random sequence of channel writes, completions, result reads and overwrite-policy changes is compared against a bench model of the flag and the result register.

// File: rtl/adc_regif.sv
module adc_regif #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int RW = 12,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_valid,
  input  logic          bus_write,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_err,
  output logic          irq,
  output logic          conv_start,
  output logic          conv_stop,
  output logic [CW-1:0] conv_chan,
  input  logic          conv_done,
  input  logic [RW-1:0] conv_result,
  output logic          cal_start,
  input  logic          cal_done,
  output logic          avg_en
);
  localparam logic [CW-1:0] STOP_CODE = '1;
  localparam logic [AW-1:0] LAST_ADDR = AW'(48);
  localparam int IW = AW - 2;

  logic          addr_ok, wr, rd;
  logic [IW-1:0] widx;
  logic          misc_hit;
  logic [1:0]    misc_sel;
  logic [DW-1:0] rd_mux;

  logic [CW-1:0] hc0_chan;
  logic          hc0_ie;
  logic [7:0]    hc1_q;
  logic          coco_q;
  logic [RW-1:0] r0_q;
  logic [16:0]   cfg_q;
  logic [6:0]    gc_q;
  logic          cal_q, calf_q, cal_irq;
  logic [DW-1:0] misc_q [4];

  assign addr_ok = (bus_addr[1:0] == 2'b00) && (bus_addr <= LAST_ADDR);
  assign wr      = bus_valid & bus_write & addr_ok;
  assign rd      = bus_valid & ~bus_write & addr_ok;
  assign widx    = bus_addr[AW-1:2];

  assign irq       = (coco_q & hc0_ie) | cal_irq;
  assign conv_chan = hc0_chan;
  assign avg_en    = gc_q[5];

  always_comb begin
    misc_hit = 1'b1;
    misc_sel = 2'd0;
    case (widx)
      IW'(8):  misc_sel = 2'd0;
      IW'(9):  misc_sel = 2'd1;
      IW'(10): misc_sel = 2'd2;
      IW'(12): misc_sel = 2'd3;
      default: misc_hit = 1'b0;
    endcase
  end

  always_comb begin
    rd_mux = '0;
    case (widx)
      IW'(0): begin
        rd_mux[CW-1:0] = hc0_chan;
        rd_mux[7]      = hc0_ie;
      end
      IW'(1): rd_mux[7:0]    = hc1_q;
      IW'(2): rd_mux[0]      = coco_q;
      IW'(3): rd_mux[RW-1:0] = r0_q;
      IW'(5): rd_mux[16:0]   = cfg_q;
      IW'(6): rd_mux[7:0]    = {cal_q, gc_q};
      IW'(7): rd_mux[1:0]    = {calf_q, cal_q};
      default: if (misc_hit) rd_mux = misc_q[misc_sel];
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hc0_chan   <= STOP_CODE;
      hc0_ie     <= 1'b0;
      hc1_q      <= 8'h1F;
      coco_q     <= 1'b0;
      r0_q       <= '0;
      cfg_q      <= '0;
      gc_q       <= '0;
      cal_q      <= 1'b0;
      calf_q     <= 1'b0;
      cal_irq    <= 1'b0;
      conv_start <= 1'b0;
      conv_stop  <= 1'b0;
      cal_start  <= 1'b0;
      bus_rdata  <= '0;
      bus_err    <= 1'b0;
      for (int i = 0; i < 4; i++) misc_q[i] <= '0;
    end else begin
      conv_start <= 1'b0;
      conv_stop  <= 1'b0;
      cal_start  <= 1'b0;
      bus_err    <= bus_valid & ~addr_ok;
      bus_rdata  <= rd ? rd_mux : '0;

      if (rd && widx == IW'(3)) coco_q  <= 1'b0;
      if (rd && widx == IW'(7)) cal_irq <= 1'b0;

      if (conv_done) begin
        if (!coco_q || cfg_q[16]) begin
          r0_q   <= conv_result;
          coco_q <= 1'b1;
        end
        if (gc_q[6] && hc0_chan != STOP_CODE) conv_start <= 1'b1;
      end

      if (cal_done && cal_q) begin
        cal_q <= 1'b0;
        if (hc0_ie) cal_irq <= 1'b1;
      end

      if (wr) begin
        case (widx)
          IW'(0): begin
            hc0_chan   <= bus_wdata[CW-1:0];
            hc0_ie     <= bus_wdata[7];
            coco_q     <= 1'b0;
            cal_irq    <= 1'b0;
            conv_start <= (bus_wdata[CW-1:0] != STOP_CODE);
            conv_stop  <= (bus_wdata[CW-1:0] == STOP_CODE);
            if (cal_q) begin
              cal_q  <= 1'b0;
              calf_q <= 1'b1;
            end
          end
          IW'(1): hc1_q <= bus_wdata[7:0];
          IW'(5): cfg_q <= bus_wdata[16:0];
          IW'(6): begin
            gc_q <= bus_wdata[6:0];
            if (bus_wdata[7] && !cal_q) begin
              cal_q     <= 1'b1;
              calf_q    <= 1'b0;
              cal_start <= 1'b1;
            end
          end
          default: if (misc_hit) misc_q[misc_sel] <= bus_wdata;
        endcase
      end
    end
  end
endmodule

// File: rtl/adc_regif_chk.sv
module adc_regif_chk #(
  parameter int AW = 8,
  parameter int RW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_valid,
  input logic          bus_write,
  input logic [AW-1:0] bus_addr,
  input logic          bus_err,
  input logic          irq,
  input logic          conv_start,
  input logic          conv_stop,
  input logic          conv_done,
  input logic          cal_done,
  input logic          coco,
  input logic          ie,
  input logic          ovw,
  input logic [RW-1:0] r0,
  input logic          cal_act,
  input logic          cal_fail
);
  logic hc0_wr;
  assign hc0_wr = bus_valid && bus_write && (bus_addr == '0);

  AST_BAD_ACCESS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && (bus_addr[1:0] != 2'b00 || bus_addr > AW'(48))) |=> bus_err); // R1
  AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(conv_start && conv_stop)); // R3
  AST_FLAG_DRIVES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (coco && ie) |-> irq); // R6
  AST_KEEP_UNREAD: assert property (@(posedge clk) disable iff (!rst_n)
    (coco && !ovw && conv_done && !hc0_wr) |=> $stable(r0)); // R7
  AST_CAL_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_act && cal_done) |=> !cal_act); // R9
  AST_CAL_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (cal_act && hc0_wr) |=> (cal_fail && !cal_act)); // R10
endmodule

bind adc_regif adc_regif_chk #(.AW(AW), .RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_err(bus_err), .irq(irq), .conv_start(conv_start),
  .conv_stop(conv_stop), .conv_done(conv_done), .cal_done(cal_done),
  .coco(coco_q), .ie(hc0_ie), .ovw(cfg_q[16]), .r0(r0_q),
  .cal_act(cal_q), .cal_fail(calf_q)
);

// File: tb/adc_regif_bench.sv
module adc_regif_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_err, irq, conv_start, conv_stop, cal_start, avg_en;
  logic [4:0]  conv_chan;
  logic        conv_done = 1'b0, cal_done = 1'b0;
  logic [11:0] conv_result = '0;

  int checks = 0, fails = 0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  adc_regif u_adc_regif (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .irq(irq), .conv_start(conv_start), .conv_stop(conv_stop),
    .conv_chan(conv_chan), .conv_done(conv_done), .conv_result(conv_result),
    .cal_start(cal_start), .cal_done(cal_done), .avg_en(avg_en)
  );

  function automatic logic exp_irq(logic f, logic e);
    return f & e;
  endfunction

  function automatic logic [11:0] exp_r0(logic f, logic ovw, logic [11:0] old, logic [11:0] nw);
    return (!f || ovw) ? nw : old;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    d = bus_rdata;
  endtask

  task automatic done(logic [11:0] v);
    @(negedge clk);
    conv_done = 1'b1; conv_result = v;
    @(negedge clk);
    conv_done = 1'b0;
  endtask

  task automatic cdone();
    @(negedge clk);
    cal_done = 1'b1;
    @(negedge clk);
    cal_done = 1'b0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic m_f, m_ie, m_ovw;
    logic [11:0] m_r0;
    int unsigned seed;
    seed = $urandom(32'h5EED);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2, R6 reset state
    rd(8'h00, rv); chk("R2 reset chan ctl", rv, 32'h1F);
    chk("R6 reset irq", {31'b0, irq}, 0);
    rd(8'h08, rv); chk("R4 reset status", rv, 0);

    // R3 start
    wr(8'h00, 32'h83);
    chk("R3 start pulse", {31'b0, conv_start}, 1);
    chk("R3 start chan", {27'b0, conv_chan}, 3);
    chk("R3 no stop", {31'b0, conv_stop}, 0);
    @(negedge clk); chk("R3 single pulse", {31'b0, conv_start}, 0);
    rd(8'h00, rv); chk("R2 chan ctl readback", rv, 32'h83);

    // R4, R6, R5
    done(12'hABC);
    chk("R6 irq on flag", {31'b0, irq}, 1);
    rd(8'h08, rv); chk("R4 status flag", rv, 1);
    rd(8'h0C, rv); chk("R4 result", rv, 32'hABC);
    rd(8'h08, rv); chk("R5 flag cleared by read", rv, 0);
    chk("R6 irq low", {31'b0, irq}, 0);

    // R7
    done(12'h111); done(12'h222);
    rd(8'h0C, rv); chk("R7 unread kept", rv, 32'h111);
    wr(8'h14, 32'h0001_0000);
    rd(8'h14, rv); chk("R11 cfg readback", rv, 32'h0001_0000);
    done(12'h444); done(12'h555);
    rd(8'h0C, rv); chk("R7 overwrite", rv, 32'h555);

    // R3 stop, R5 write clears
    done(12'h666);
    wr(8'h00, 32'h1F);
    chk("R3 stop pulse", {31'b0, conv_stop}, 1);
    chk("R3 stop no start", {31'b0, conv_start}, 0);
    rd(8'h08, rv); chk("R5 flag cleared by write", rv, 0);

    // R1
    wr(8'h16, 32'h0);
    chk("R1 unaligned err", {31'b0, bus_err}, 1);
    rd(8'h14, rv); chk("R1 rejected write", rv, 32'h0001_0000);
    chk("R1 good access no err", {31'b0, bus_err}, 0);
    wr(8'h34, 32'h1234);
    chk("R1 high err", {31'b0, bus_err}, 1);
    rd(8'h40, rv); chk("R1 rejected read zero", rv, 0);
    chk("R1 read err", {31'b0, bus_err}, 1);

    // R11
    wr(8'h04, 32'h85); rd(8'h04, rv); chk("R11 chan ctl 1", rv, 32'h85);
    wr(8'h20, 32'hDEAD0001); wr(8'h24, 32'hDEAD0002);
    wr(8'h28, 32'hDEAD0003); wr(8'h30, 32'hDEAD0004);
    rd(8'h20, rv); chk("R11 reg 20", rv, 32'hDEAD0001);
    rd(8'h28, rv); chk("R11 reg 28", rv, 32'hDEAD0003);
    rd(8'h30, rv); chk("R11 reg 30", rv, 32'hDEAD0004);
    wr(8'h18, 32'h20); chk("R11 avg_en", {31'b0, avg_en}, 1);

    // R8
    wr(8'h18, 32'h40);
    wr(8'h00, 32'h05);
    done(12'h010);
    chk("R8 restart", {31'b0, conv_start}, 1);
    chk("R8 restart chan", {27'b0, conv_chan}, 5);
    done(12'h020);
    chk("R8 restart again", {31'b0, conv_start}, 1);
    wr(8'h00, 32'h1F);
    done(12'h030);
    chk("R8 no restart after stop", {31'b0, conv_start}, 0);
    wr(8'h18, 32'h0);

    // R9
    wr(8'h00, 32'h9F);
    wr(8'h18, 32'h80);
    chk("R9 cal start", {31'b0, cal_start}, 1);
    rd(8'h18, rv); chk("R9 cal bit set", rv, 32'h80);
    rd(8'h1C, rv); chk("R9 active mirror", rv, 32'h1);
    cdone();
    rd(8'h18, rv); chk("R9 cal bit cleared", rv, 0);
    chk("R9 cal irq", {31'b0, irq}, 1);
    rd(8'h1C, rv); chk("R9 no fail", rv, 0);
    chk("R9 irq cleared by status read", {31'b0, irq}, 0);

    // R10
    wr(8'h18, 32'h80);
    wr(8'h00, 32'h02);
    rd(8'h1C, rv); chk("R10 abort flag", rv, 32'h2);
    rd(8'h18, rv); chk("R10 cal ended", rv, 0);
    wr(8'h18, 32'h80);
    rd(8'h1C, rv); chk("R10 fail cleared on restart", rv, 32'h1);
    cdone();
    wr(8'h18, 32'h0);

    // random: R4 R5 R6 R7
    wr(8'h00, 32'h1F);
    wr(8'h14, 32'h0);
    m_f = 0; m_ie = 0; m_ovw = 0; m_r0 = 12'h030;
    for (int i = 0; i < 400; i++) begin
      int unsigned op;
      op = $urandom_range(0, 4);
      case (op)
        0: begin
          logic [4:0] c; logic e;
          c = 5'($urandom_range(0, 30)); e = 1'($urandom);
          wr(8'h00, {24'b0, e, 2'b0, c});
          chk("R3 random start", {26'b0, conv_start, conv_chan}, {26'b0, 1'b1, c});
          m_f = 0; m_ie = e;
        end
        1: begin
          logic [11:0] v;
          v = 12'($urandom);
          done(v);
          m_r0 = exp_r0(m_f, m_ovw, m_r0, v);
          m_f = 1;
        end
        2: begin
          rd(8'h0C, rv); chk("R4 random result", rv, {20'b0, m_r0});
          m_f = 0;
        end
        3: begin
          m_ovw = 1'($urandom);
          wr(8'h14, {15'b0, m_ovw, 16'h0});
        end
        default: begin
          chk("R6 random irq", {31'b0, irq}, {31'b0, exp_irq(m_f, m_ie)});
          rd(8'h08, rv); chk("R5 random status", rv, {31'b0, m_f});
        end
      endcase
    end
    summary();
  end
endmodule